// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Unit

This unit fetches one instruction at a time from a byte-wide memory and hands it to an execute stage. An instruction is between one and six bytes long. The first byte is the opcode, and its value alone sets how many operand bytes follow. Each byte is read with its own request/acknowledge transaction. The read address is the 16-bit code segment shifted left by four bits plus the 16-bit instruction pointer, taken modulo 2^20.

The instruction pointer moves forward one step for each byte taken and wraps within 16 bits. The bytes go into a 48-bit instruction register in the order they were read. Slots that the instruction does not fill read as zero. When the last byte has arrived, the unit raises a valid level. It then waits for the execute stage to request the next instruction.

A halt opcode is still delivered as a normal one-byte instruction. When the execute stage asks for the instruction after it, the unit parks in a halted state and issues no further memory requests until reset. Segment and pointer values can be loaded while no fetch is in flight.

Top module: `ifu_fetch`

## Requirements
- R1: While reset is low and in the first cycle after it, `mem_req`, `ir_valid` and `halted` are 0. `ip_out`, `cs_out`, `ir_data` and `ir_len` are all 0.
- R2: While `mem_req` is 1, `mem_addr` equals (`cs_out` × 16 + `ip_out`) mod 2^20. It does not change until the cycle in which `mem_ack` is sampled high.
- R3: The length depends on opcode bits [7:5]: 000 gives 1 byte, 001 gives 2, 010 gives 3, 011 gives 4 and 100 gives 6. Every other value gives 1. `ir_len` reports this length while `ir_valid` is 1.
- R4: The byte read k-th (k = 0 for the opcode) sits in `ir_data[8k+7:8k]`. Bytes are not reordered, and slots at and above the length read as 0.
- R5: Each accepted byte adds 1 to `ip_out`, modulo 2^16. A completed instruction therefore leaves the pointer advanced by its length, and `cs_out` is unchanged.
- R6: `ir_valid` rises in the cycle after the last byte's acknowledge and stays high until `next_req` is sampled. `mem_req` is 0 while `ir_valid` is 1. The next opcode request starts in the cycle after `next_req`.
- R7: Opcode F4h is the halt opcode. It is delivered as a one-byte instruction. A later `next_req` raises `halted`, which stays 1 until reset, and `mem_req` then stays 0.
- R8: `load_en` copies `cs_in` and `ip_in` into the segment and pointer only while the unit is idle or holding a valid instruction. During a fetch, `load_en` is ignored.
- R9: `mem_req` stays high until it is acknowledged. Exactly as many bytes are acknowledged per instruction as its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Load segment and pointer from `cs_in` and `ip_in` |
| cs_in | input | 16 | Code segment value to load |
| ip_in | input | 16 | Instruction pointer value to load |
| next_req | input | 1 | Execute stage asks for the next instruction |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 20 | Byte read address |
| mem_ack | input | 1 | Read acknowledge; `mem_rdata` is valid with it |
| mem_rdata | input | 8 | Read data byte |
| cs_out | output | 16 | Current code segment |
| ip_out | output | 16 | Current instruction pointer |
| ir_data | output | 48 | Instruction register, first byte in the low slot |
| ir_len | output | 3 | Instruction length in bytes |
| ir_valid | output | 1 | Instruction complete and waiting |
| halted | output | 1 | Halt reached; fetching stopped |

## Verification
A wrong byte counter or length register shows at the ports within one instruction. The number of acknowledged reads no longer matches the opcode class, and `ir_data` gets a stray or missing slot at the moment `ir_valid` rises. A pointer that slips shows on the very next request, because every address the memory model sees is compared with the segment and pointer it predicts. A state machine that leaves the halted state, or that takes a load during a fetch, produces either a request within the following window of idle cycles or a pointer that differs from the expected value once the instruction completes.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_FETCH_OP = 3'd1,
    ST_FETCH_OR = 3'd2,
    ST_READY    = 3'd3,
    ST_HALTED   = 3'd4
  } ifu_state_e;

endpackage

// File: rtl/ifu_len_decode.sv
module ifu_len_decode #(
  parameter int LEN_W = 3
) (
  input  logic [7:0]       opcode,
  output logic [LEN_W-1:0] len
);

  always_comb begin
    case (opcode[7:5])
      3'b000:  len = LEN_W'(1);
      3'b001:  len = LEN_W'(2);
      3'b010:  len = LEN_W'(3);
      3'b011:  len = LEN_W'(4);
      3'b100:  len = LEN_W'(6);
      default: len = LEN_W'(1);
    endcase
  end

endmodule

// File: rtl/ifu_addr_gen.sv
module ifu_addr_gen #(
  parameter int SEG_W     = 16,
  parameter int IP_W      = 16,
  parameter int SEG_SHIFT = 4,
  parameter int ADDR_W    = 20
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [IP_W-1:0]   ptr,
  output logic [ADDR_W-1:0] addr
);

  localparam int BASE_W = SEG_W + SEG_SHIFT;

  logic [BASE_W-1:0] base;

  always_comb begin
    base = {seg, {SEG_SHIFT{1'b0}}};
    addr = ADDR_W'(base) + ADDR_W'(ptr);
  end

endmodule

// File: rtl/ifu_ir_assemble.sv
module ifu_ir_assemble #(
  parameter int MAX_BYTES = 6,
  parameter int LEN_W     = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   wr_en,
  input  logic [LEN_W-1:0]       wr_slot,
  input  logic [7:0]             wr_data,
  output logic [MAX_BYTES*8-1:0] ir
);

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_slot
    logic [7:0] slot_q;
    logic       slot_we;

    assign slot_we = wr_en && (wr_slot == LEN_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= 8'h00;
      end else if (clr) begin
        slot_q <= 8'h00;
      end else if (slot_we) begin
        slot_q <= wr_data;
      end
    end

    assign ir[g*8 +: 8] = slot_q;
  end

endmodule

// File: rtl/ifu_fetch.sv
module ifu_fetch #(
  parameter int         SEG_W     = 16,
  parameter int         IP_W      = 16,
  parameter int         SEG_SHIFT = 4,
  parameter int         ADDR_W    = 20,
  parameter int         MAX_BYTES = 6,
  parameter logic [7:0] HALT_OP   = 8'hF4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_en,
  input  logic [SEG_W-1:0]       cs_in,
  input  logic [IP_W-1:0]        ip_in,
  input  logic                   next_req,
  output logic                   mem_req,
  output logic [ADDR_W-1:0]      mem_addr,
  input  logic                   mem_ack,
  input  logic [7:0]             mem_rdata,
  output logic [SEG_W-1:0]       cs_out,
  output logic [IP_W-1:0]        ip_out,
  output logic [MAX_BYTES*8-1:0] ir_data,
  output logic [2:0]             ir_len,
  output logic                   ir_valid,
  output logic                   halted
);

  import ifu_pkg::*;

  localparam int LEN_W = $clog2(MAX_BYTES + 1);

  ifu_state_e       state_q, state_d;
  logic [SEG_W-1:0] cs_q, cs_d;
  logic [IP_W-1:0]  ip_q, ip_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             hlt_q, hlt_d;
  logic [LEN_W-1:0] dec_len;
  logic             take;
  logic             in_fetch;
  logic             can_load;
  logic             ir_clr;
  logic [LEN_W-1:0] wr_slot;

  ifu_len_decode #(.LEN_W(LEN_W)) u_dec (
    .opcode (mem_rdata),
    .len    (dec_len)
  );

  ifu_addr_gen #(
    .SEG_W(SEG_W), .IP_W(IP_W), .SEG_SHIFT(SEG_SHIFT), .ADDR_W(ADDR_W)
  ) u_agen (
    .seg  (cs_q),
    .ptr  (ip_q),
    .addr (mem_addr)
  );

  ifu_ir_assemble #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_ir (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ir_clr),
    .wr_en   (take),
    .wr_slot (wr_slot),
    .wr_data (mem_rdata),
    .ir      (ir_data)
  );

  always_comb begin
    in_fetch = (state_q == ST_FETCH_OP) || (state_q == ST_FETCH_OR);
    can_load = (state_q == ST_IDLE) || (state_q == ST_READY);
    take     = in_fetch && mem_ack;
    wr_slot  = (state_q == ST_FETCH_OP) ? '0 : cnt_q;
    ir_clr   = next_req && ((state_q == ST_IDLE) ||
                            ((state_q == ST_READY) && !hlt_q));
  end

  always_comb begin
    state_d = state_q;
    cs_d    = cs_q;
    ip_d    = ip_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    hlt_d   = hlt_q;

    if (can_load && load_en) begin
      cs_d = cs_in;
      ip_d = ip_in;
    end
    if (take) begin
      ip_d = ip_q + IP_W'(1);
    end

    case (state_q)
      ST_IDLE: begin
        if (next_req) state_d = ST_FETCH_OP;
      end
      ST_FETCH_OP: begin
        if (mem_ack) begin
          len_d = dec_len;
          cnt_d = LEN_W'(1);
          hlt_d = (mem_rdata == HALT_OP);
          state_d = (dec_len == LEN_W'(1)) ? ST_READY : ST_FETCH_OR;
        end
      end
      ST_FETCH_OR: begin
        if (mem_ack) begin
          cnt_d = cnt_q + LEN_W'(1);
          if (cnt_q + LEN_W'(1) == len_q) state_d = ST_READY;
        end
      end
      ST_READY: begin
        if (next_req) state_d = hlt_q ? ST_HALTED : ST_FETCH_OP;
      end
      ST_HALTED: state_d = ST_HALTED;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_q    <= '0;
      ip_q    <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      hlt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_q    <= cs_d;
      ip_q    <= ip_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      hlt_q   <= hlt_d;
    end
  end

  assign mem_req  = in_fetch;
  assign cs_out   = cs_q;
  assign ip_out   = ip_q;
  assign ir_len   = 3'(len_q);
  assign ir_valid = (state_q == ST_READY);
  assign halted   = (state_q == ST_HALTED);

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> $stable(mem_addr)) else $error("AST_ADDR_HELD"); // R2

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req) else $error("AST_REQ_HELD"); // R9

  AST_IP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (ip_out == $past(ip_out) + IP_W'(1))) else $error("AST_IP_STEP"); // R5

  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ir_valid |-> !mem_req) else $error("AST_VALID_QUIET"); // R6

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ir_valid |-> (ir_len >= 3'd1 && ir_len <= 3'(MAX_BYTES))) else $error("AST_LEN_RANGE"); // R3

  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req) else $error("AST_HALT_SILENT"); // R7

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted) else $error("AST_HALT_STICKY"); // R7

  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> $stable(cs_out)) else $error("AST_NO_LOAD_BUSY"); // R8

endmodule

// File: tb/tb_ifu_fetch.sv
module tb_ifu_fetch;

  logic        clk;
  logic        rst_n;
  logic        load_en;
  logic [15:0] cs_in;
  logic [15:0] ip_in;
  logic        next_req;
  logic        mem_req;
  logic [19:0] mem_addr;
  logic        mem_ack;
  logic [7:0]  mem_rdata;
  logic [15:0] cs_out;
  logic [15:0] ip_out;
  logic [47:0] ir_data;
  logic [2:0]  ir_len;
  logic        ir_valid;
  logic        halted;

  ifu_fetch dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .cs_in(cs_in), .ip_in(ip_in),
    .next_req(next_req), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .cs_out(cs_out), .ip_out(ip_out),
    .ir_data(ir_data), .ir_len(ir_len), .ir_valid(ir_valid), .halted(halted)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int acks   = 0;
  int wait_cnt = 0;
  logic [15:0] exp_cs = 16'h0;
  logic [15:0] exp_ip = 16'h0;
  logic [7:0]  mem [int];

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [7:0] op);
    case (op[7:5])
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 3;
      3'b011: return 4;
      3'b100: return 6;
      default: return 1;
    endcase
  endfunction

  function automatic int lin(input logic [15:0] s, input logic [15:0] p);
    return int'((({4'h0, s} << 4) + {4'h0, p}) & 20'hFFFFF);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // memory model: stalls 0..3 cycles depending on address, checks address
  always @(negedge clk) begin
    mem_ack <= 1'b0;
    if (rst_n && mem_req) begin
      if (wait_cnt >= int'(mem_addr[1:0])) begin
        wait_cnt = 0;
        if (mem_addr != 20'(lin(exp_cs, exp_ip)))
          chk(1'b0, "R2 address", 64'(mem_addr), 64'(lin(exp_cs, exp_ip)));
        mem_ack   <= 1'b1;
        mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'hEE;
        exp_ip = exp_ip + 16'h1;
        acks++;
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic place(input logic [15:0] s, input logic [15:0] p,
                       input logic [7:0] b[6], input int n);
    logic [15:0] q;
    q = p;
    for (int k = 0; k < n; k++) begin
      mem[lin(s, q)] = b[k];
      q = q + 16'h1;
    end
  endtask

  task automatic fetch_one(input logic [7:0] b[6], input int n, input bit poke);
    logic [47:0] want;
    logic [15:0] ip0;
    int t;
    want = '0;
    for (int k = 0; k < n; k++) want[k*8 +: 8] = b[k];
    ip0 = exp_ip;
    acks = 0;
    next_req = 1'b1;
    @(negedge clk);
    next_req = 1'b0;
    if (ir_valid) chk(1'b0, "R6 valid dropped", 64'(ir_valid), 64'd0);
    if (poke) begin
      load_en = 1'b1; cs_in = 16'h0005; ip_in = 16'h1234;
      @(negedge clk);
      @(negedge clk);
      load_en = 1'b0;
    end
    t = 0;
    while (!ir_valid && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk(ir_valid == 1'b1, "R6 ready", 64'(ir_valid), 64'd1);
    if (ir_data != want) chk(1'b0, "R4 ir", 64'(ir_data), 64'(want));
    if (int'(ir_len) != n) chk(1'b0, "R3 len", 64'(ir_len), 64'(n));
    if (ip_out != 16'(ip0 + 16'(n))) chk(1'b0, "R5 ip", 64'(ip_out), 64'(ip0 + 16'(n)));
    if (acks != n) chk(1'b0, "R9 acks", 64'(acks), 64'(n));
    if (cs_out != exp_cs) chk(1'b0, "R8 cs", 64'(cs_out), 64'(exp_cs));
    checks += 5;
  endtask

  task automatic do_load(input logic [15:0] s, input logic [15:0] p);
    load_en = 1'b1; cs_in = s; ip_in = p;
    @(negedge clk);
    load_en = 1'b0;
    exp_cs = s; exp_ip = p;
  endtask

  initial begin
    logic [7:0] b[6];
    logic [15:0] pp;
    int n, busy;
    rst_n = 1'b0; load_en = 1'b0; cs_in = '0; ip_in = '0; next_req = 1'b0;
    mem_ack = 1'b0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    chk(!mem_req && !ir_valid && !halted && ip_out == 0 && cs_out == 0 &&
        ir_data == 0 && ir_len == 0, "R1 reset", 64'({mem_req, ir_valid, halted}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req && !ir_valid && ip_out == 0, "R1 after release", 64'(mem_req), 64'd0);

    do_load(16'h1000, 16'h3C08);
    chk(ip_out == 16'h3C08 && cs_out == 16'h1000, "R8 load idle", 64'(ip_out), 64'h3C08);

    // worked example: 3-byte instruction 4B 36 FF
    b = '{8'h4B, 8'h36, 8'hFF, 8'h00, 8'h00, 8'h00};
    place(16'h1000, 16'h3C08, b, 3);
    fetch_one(b, 3, 1'b0);
    chk(ip_out == 16'h3C0B, "R5 example", 64'(ip_out), 64'h3C0B);

    // sweep every opcode except halt
    pp = 16'h3C0B;
    for (int op = 0; op < 256; op++) begin
      if (op == 8'hF4) continue;
      n = exp_len(8'(op));
      b[0] = 8'(op);
      for (int k = 1; k < 6; k++) b[k] = 8'(op * 7 + k * 8'h5A + 1);
      place(16'h1000, pp, b, n);
      fetch_one(b, n, 1'b0);
      pp = pp + 16'(n);
    end

    // load attempted mid-fetch on a 6-byte instruction is ignored
    b = '{8'h80, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    place(16'h1000, pp, b, 6);
    fetch_one(b, 6, 1'b1);
    chk(cs_out == 16'h1000 && ip_out == 16'(pp + 16'd6), "R8 busy load ignored",
        64'(ip_out), 64'(pp + 16'd6));

    // load in ready state, then wraparound of the pointer
    do_load(16'h2000, 16'hFFFE);
    chk(ip_out == 16'hFFFE && cs_out == 16'h2000, "R8 load ready", 64'(ip_out), 64'hFFFE);
    b = '{8'h40, 8'hA1, 8'hA2, 8'h00, 8'h00, 8'h00};
    place(16'h2000, 16'hFFFE, b, 3);
    chk(lin(16'h2000, 16'h0000) == 32'h20000, "R2 wrap addr", 64'(lin(16'h2000, 16'h0)), 64'h20000);
    fetch_one(b, 3, 1'b0);
    chk(ip_out == 16'h0001, "R5 wrap", 64'(ip_out), 64'h0001);

    // halt opcode delivered, then unit parks
    b = '{8'hF4, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    place(16'h2000, 16'h0001, b, 1);
    fetch_one(b, 1, 1'b0);
    chk(!halted, "R7 halt delivered first", 64'(halted), 64'd0);
    next_req = 1'b1;
    @(negedge clk);
    next_req = 1'b0;
    chk(halted && !ir_valid, "R7 halted", 64'(halted), 64'd1);
    busy = 0;
    for (int c = 0; c < 40; c++) begin
      next_req = c[0];
      @(negedge clk);
      if (mem_req || !halted) busy++;
    end
    next_req = 1'b0;
    chk(busy == 0, "R7 silent", 64'(busy), 64'd0);
    chk(ip_out == 16'h0002, "R7 ip frozen", 64'(ip_out), 64'h0002);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!halted && ip_out == 0 && ir_data == 0, "R1 reset after halt", 64'(halted), 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule